// File: doc/BRIEF.md
# Serial Control-Port Slave with Sticky Mode Entry

This block is the slave side of a four-wire serial control port on a register-mapped device. It comes out of reset in an alternate control mode. It switches into SPI mode only after its select line has gone low three times, and it stays in that mode until the next full reset. All pin activity is captured by the system clock. Every pin passes through a synchronizer, and edge detection produces one-cycle events for select falling, serial clock rising and serial clock falling.

In SPI mode, each transaction begins with a header of three bytes. The first byte carries the chip identity and the direction. The next two bytes carry a subaddress, high byte first. Data bytes follow. The subaddress is loaded into an internal byte pointer, and the pointer advances by one after every complete data byte, so one header can be followed by a burst of any length. Writes land in an internal byte-wide register file. Reads are prefetched so that the first data bit is already on the serial output before the first rising clock edge of the fourth byte.

Part of the register file is a guarded window. That window can only be reached while a clock-enable bit and two power bits, which live in two always-reachable control bytes, are all set. A separate host-side port lets the surrounding logic look at any stored byte directly.

Top module: `spi_ctrl_port`

## Requirements
- R1: After reset `spi_mode` is 0. It becomes 1 after the third falling edge of `spi_cs_n` and then stays 1 until reset. Frames sent during the three entry pulses, including the third, have no effect on the register file.
- R2: Bits on `spi_mosi` are sampled on `spi_sclk` rising edges, most significant bit first. Byte 0 is `{7-bit chip id, dir}`, where dir 1 means read and 0 means write. Bytes 1 and 2 are the subaddress, high byte first. A write stores byte 3 at the subaddress.
- R3: `spi_miso` changes only after a falling edge of `spi_sclk`. Read data is presented most significant bit first, so it is valid at each rising edge.
- R4: `spi_miso_oe` is 0 during the three header bytes and throughout write transactions. During a read it becomes 1 at the last falling edge of byte 2, so it is high from the first bit of byte 3 onward. It returns to 0 once `spi_cs_n` rises.
- R5: If the chip id in byte 0 is not 0x38, the rest of the transaction is ignored: nothing is written and `spi_miso_oe` stays 0.
- R6: Only the low 12 bits of the subaddress select a byte. The upper 4 bits are ignored.
- R7: Each complete data byte advances the byte pointer by one, for both burst writes and burst reads.
- R8: If a transaction ends partway through a byte, that partial byte is discarded. Bytes completed before it are kept.
- R9: Bytes 0x0A0 to 0x0BF are reachable only while bit 0 of byte 0x000 and bits 6 and 0 of byte 0x080 are all 1. Otherwise a write to the window is dropped and a read from it returns 0x00.
- R10: The register file holds bytes 0x000 to 0x0BF. Writes above 0x0BF are dropped, and reads above it return 0x00, both over SPI and on `rf_rdata`.
- R11: Reset clears every stored byte to 0x00. `rf_rdata` shows the stored byte at `rf_addr` without the window guard applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_cs_n | input | 1 | Active-low select |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, driven low whenever not enabled |
| spi_miso_oe | output | 1 | Output enable for the external tri-state pad |
| spi_mode | output | 1 | High once SPI mode has been entered |
| rf_addr | input | 12 | Host-side byte address |
| rf_rdata | output | 8 | Stored byte at `rf_addr` (0x00 above the file) |

## Verification
Each serial pin passes through two synchronizer flops and one edge-detect flop. Any effect of a pin edge therefore appears in the register that consumes it on the third system clock edge after the pin changes. A stored byte appears on `rf_rdata` combinationally from that point. The bench holds every serial-clock half period for eight system clocks and drives and samples only on falling system clock edges. Output data and enable are read just before each serial rising edge, and register contents are read only after select has been high for sixteen cycles. This way every sample falls well after the due cycle and before the next stimulus.

// File: rtl/spi_cp_pkg.sv
package spi_cp_pkg;
  localparam int          SUB_W       = 12;
  localparam int          BYTE_W      = 8;
  localparam logic [6:0]  CHIP_ID     = 7'h38;
  localparam int          ENTRY_EDGES = 3;
  localparam int          HDR_BYTES   = 3;
  typedef logic [SUB_W-1:0]  sub_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spi_cp_sync.sv
module spi_cp_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  input  logic sclk_pin,
  input  logic mosi_pin,
  output logic rst_sn,
  output logic cs_s,
  output logic cs_fall,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s
);
  localparam logic [2:0] IDLE = 3'b100;
  logic [2:0] pin_raw;
  logic [2:0] stg_q [SYNC_STAGES+1];
  logic [1:0] rs_q;

  assign pin_raw = {cs_n_pin, sclk_pin, mosi_pin};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  assign rst_sn = rs_q[1];

  for (genvar s = 0; s <= SYNC_STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q[0] <= IDLE;
        else        stg_q[0] <= pin_raw;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q[s] <= IDLE;
        else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign cs_s      = stg_q[SYNC_STAGES-1][2];
  assign cs_fall   = stg_q[SYNC_STAGES][2] & ~stg_q[SYNC_STAGES-1][2];
  assign sclk_rise = stg_q[SYNC_STAGES-1][1] & ~stg_q[SYNC_STAGES][1];
  assign sclk_fall = stg_q[SYNC_STAGES][1] & ~stg_q[SYNC_STAGES-1][1];
  assign mosi_s    = stg_q[SYNC_STAGES-1][0];
endmodule

// File: rtl/spi_cp_mode.sv
module spi_cp_mode
  import spi_cp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_fall,
  output logic mode_o
);
  localparam int CNT_W = $clog2(ENTRY_EDGES + 1);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             mode_q, mode_n;

  always_comb begin
    cnt_n  = cnt_q;
    mode_n = mode_q;
    if (cs_fall && !mode_q) begin
      cnt_n = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(ENTRY_EDGES - 1)) mode_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      mode_q <= mode_n;
    end

  assign mode_o = mode_q;

  // R1
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> mode_q);
endmodule

// File: rtl/spi_cp_frame.sv
module spi_cp_frame
  import spi_cp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_i,
  input  logic  cs_s,
  input  logic  cs_fall,
  input  logic  sclk_rise,
  input  logic  sclk_fall,
  input  logic  mosi_s,
  input  byte_t rd_data_i,
  output sub_t  rd_addr_o,
  output logic  wr_en_o,
  output sub_t  wr_addr_o,
  output byte_t wr_data_o,
  output logic  miso_o,
  output logic  miso_oe_o
);
  localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);
  localparam logic [1:0] DATA_PH  = 2'(HDR_BYTES);

  logic       active_q, active_n;
  logic [2:0] bit_q, bit_n;
  logic [1:0] byte_q, byte_n;
  logic [6:0] sh_q, sh_n;
  logic       rw_q, rw_n, bad_q, bad_n;
  logic [3:0] hi_q, hi_n;
  sub_t       cur_q, cur_n;
  byte_t      tx_q, tx_n, buf_q, buf_n;
  logic       load_q, load_n, oe_q, oe_n, miso_q, miso_n;
  byte_t      full;
  logic       byte_done;

  assign full      = {sh_q, mosi_s};
  assign byte_done = active_q & ~cs_s & sclk_rise & (bit_q == LAST_BIT);
  assign rd_addr_o = (byte_q == DATA_PH - 2'd1) ? {hi_q, full} : cur_q + SUB_W'(1);
  assign wr_en_o   = byte_done & (byte_q == DATA_PH) & ~rw_q & ~bad_q;
  assign wr_addr_o = cur_q;
  assign wr_data_o = full;

  always_comb begin
    active_n = active_q; bit_n = bit_q; byte_n = byte_q; sh_n = sh_q;
    rw_n = rw_q; bad_n = bad_q; hi_n = hi_q; cur_n = cur_q;
    tx_n = tx_q; buf_n = buf_q; load_n = load_q; oe_n = oe_q; miso_n = miso_q;
    if (cs_fall) active_n = mode_i;
    if (cs_s) begin
      bit_n = '0; byte_n = '0; load_n = 1'b0; oe_n = 1'b0;
    end else if (active_q && sclk_rise) begin
      sh_n  = full[6:0];
      bit_n = bit_q + 3'd1;
      if (byte_done) begin
        byte_n = (byte_q == DATA_PH) ? byte_q : byte_q + 2'd1;
        case (byte_q)
          2'd0: begin rw_n = full[0]; bad_n = (full[7:1] != CHIP_ID); end
          2'd1: hi_n = full[3:0];
          2'd2: cur_n = {hi_q, full};
          default: cur_n = cur_q + SUB_W'(1);
        endcase
        if (byte_q >= DATA_PH - 2'd1 && rw_q && !bad_q) begin
          load_n = 1'b1;
          buf_n  = rd_data_i;
        end
      end
    end else if (active_q && sclk_fall) begin
      if (load_q) begin
        miso_n = buf_q[7];
        tx_n   = {buf_q[6:0], 1'b0};
        load_n = 1'b0;
        oe_n   = 1'b1;
      end else begin
        miso_n = tx_q[7];
        tx_n   = {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active_q <= 1'b0; bit_q <= '0; byte_q <= '0; sh_q <= '0;
      rw_q <= 1'b0; bad_q <= 1'b0; hi_q <= '0; cur_q <= '0;
      tx_q <= '0; buf_q <= '0; load_q <= 1'b0; oe_q <= 1'b0; miso_q <= 1'b0;
    end else begin
      active_q <= active_n; bit_q <= bit_n; byte_q <= byte_n; sh_q <= sh_n;
      rw_q <= rw_n; bad_q <= bad_n; hi_q <= hi_n; cur_q <= cur_n;
      tx_q <= tx_n; buf_q <= buf_n; load_q <= load_n; oe_q <= oe_n; miso_q <= miso_n;
    end

  assign miso_o    = miso_q;
  assign miso_oe_o = oe_q;

  // R4
  oe_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe_o |-> mode_i);
  // R3
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(miso_q));
  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_q == 3'd0 && byte_q == 2'd0));
  // R5
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_q && byte_q == DATA_PH) |-> (!miso_oe_o && !wr_en_o));
endmodule

// File: rtl/spi_cp_regfile.sv
module spi_cp_regfile
  import spi_cp_pkg::*;
#(
  parameter int   DEPTH   = 192,
  parameter sub_t GATE_LO = 12'h0A0,
  parameter sub_t GATE_HI = 12'h0BF,
  parameter sub_t CLK_REG = 12'h000,
  parameter sub_t PWR_REG = 12'h080
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en_i,
  input  sub_t  wr_addr_i,
  input  byte_t wr_data_i,
  input  sub_t  rd_addr_i,
  output byte_t rd_data_o,
  input  sub_t  host_addr_i,
  output byte_t host_data_o
);
  localparam int IDX_W = $clog2(DEPTH);
  byte_t mem_q [DEPTH];
  logic  gate_open, wr_ok;

  function automatic logic in_file(sub_t a);
    return a < SUB_W'(DEPTH);
  endfunction
  function automatic logic in_gate(sub_t a);
    return (a >= GATE_LO) && (a <= GATE_HI);
  endfunction

  assign gate_open = mem_q[CLK_REG[IDX_W-1:0]][0] &
                     mem_q[PWR_REG[IDX_W-1:0]][6] & mem_q[PWR_REG[IDX_W-1:0]][0];
  assign wr_ok = wr_en_i & in_file(wr_addr_i) & (~in_gate(wr_addr_i) | gate_open);

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                               mem_q[i] <= '0;
      else if (wr_ok && wr_addr_i == SUB_W'(i)) mem_q[i] <= wr_data_i;
  end

  assign rd_data_o = (in_file(rd_addr_i) && (!in_gate(rd_addr_i) || gate_open))
                     ? mem_q[rd_addr_i[IDX_W-1:0]] : '0;
  assign host_data_o = in_file(host_addr_i) ? mem_q[host_addr_i[IDX_W-1:0]] : '0;

  // R9
  gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(gate_open));
endmodule

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port
  import spi_cp_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter int   RF_DEPTH    = 192,
  parameter sub_t GATE_LO     = 12'h0A0,
  parameter sub_t GATE_HI     = 12'h0BF,
  parameter sub_t CLK_REG     = 12'h000,
  parameter sub_t PWR_REG     = 12'h080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_cs_n,
  input  logic        spi_sclk,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        spi_miso_oe,
  output logic        spi_mode,
  input  logic [11:0] rf_addr,
  output logic [7:0]  rf_rdata
);
  logic  rst_sn, cs_s, cs_fall, sclk_rise, sclk_fall, mosi_s;
  logic  mode, wr_en, miso_raw, oe;
  sub_t  rd_addr, wr_addr;
  byte_t rd_data, wr_data;

  spi_cp_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(spi_cs_n), .sclk_pin(spi_sclk),
    .mosi_pin(spi_mosi), .rst_sn(rst_sn), .cs_s(cs_s), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s));

  spi_cp_mode u_mode (
    .clk(clk), .rst_n(rst_sn), .cs_fall(cs_fall), .mode_o(mode));

  spi_cp_frame u_frame (
    .clk(clk), .rst_n(rst_sn), .mode_i(mode), .cs_s(cs_s), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .miso_o(miso_raw), .miso_oe_o(oe));

  spi_cp_regfile #(.DEPTH(RF_DEPTH), .GATE_LO(GATE_LO), .GATE_HI(GATE_HI),
                   .CLK_REG(CLK_REG), .PWR_REG(PWR_REG)) u_rf (
    .clk(clk), .rst_n(rst_sn), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .host_addr_i(rf_addr), .host_data_o(rf_rdata));

  assign spi_miso    = oe & miso_raw;
  assign spi_miso_oe = oe;
  assign spi_mode    = mode;
endmodule

// File: tb/spi_ctrl_port_test.sv
module spi_ctrl_port_test;
  localparam int H  = 8;
  localparam int WD = 150000;
  localparam logic [6:0] ID = 7'h38;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe, spi_mode;
  logic [11:0] rf_addr = '0;
  logic [7:0]  rf_rdata;

  int checks = 0, failures = 0;
  logic finished = 1'b0;
  logic [7:0] tx_buf [0:39];
  logic [7:0] rx_buf [0:39];
  logic       oe_any [0:39];

  always #10 clk = ~clk;

  spi_ctrl_port uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .spi_mode(spi_mode), .rf_addr(rf_addr), .rf_rdata(rf_rdata));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [11:0] a, output logic [7:0] d);
    rf_addr = a; #1; d = rf_rdata;
  endtask

  task automatic spi_byte(input int idx, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi = tx_buf[idx][i];
      repeat (H) @(negedge clk);
      rx_buf[idx][i] = spi_miso;
      if (spi_miso_oe) oe_any[idx] = 1'b1;
      spi_sclk = 1'b1;
      repeat (H) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic xact(input int nfull, input int tail);
    for (int b = 0; b < 40; b++) begin rx_buf[b] = '0; oe_any[b] = 1'b0; end
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int b = 0; b < nfull; b++) spi_byte(b, 8);
    if (tail > 0) spi_byte(nfull, tail);
    repeat (H) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic hdr(input logic [6:0] id, input logic rw, input logic [15:0] sub);
    tx_buf[0] = {id, rw}; tx_buf[1] = sub[15:8]; tx_buf[2] = sub[7:0];
    for (int b = 3; b < 40; b++) tx_buf[b] = '0;
  endtask

  task automatic wr1(input logic [15:0] sub, input logic [7:0] d);
    hdr(ID, 1'b0, sub); tx_buf[3] = d; xact(4, 0);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL all watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, prev;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R11 reset state
    chk("R1 mode after reset", {7'b0, spi_mode}, 8'h00);
    chk("R4 oe after reset", {7'b0, spi_miso_oe}, 8'h00);
    peek(12'h000, d); chk("R11 byte 000 cleared", d, 8'h00);
    peek(12'h0A5, d); chk("R11 byte 0A5 cleared", d, 8'h00);

    // R1 entry pulses, two of them carrying frames
    wr1(16'h0010, 8'h5A);
    chk("R1 mode after one pulse", {7'b0, spi_mode}, 8'h00);
    spi_cs_n = 1'b0; repeat (H) @(negedge clk); spi_cs_n = 1'b1; repeat (2*H) @(negedge clk);
    chk("R1 mode after two pulses", {7'b0, spi_mode}, 8'h00);
    wr1(16'h0011, 8'h22);
    chk("R1 mode after three pulses", {7'b0, spi_mode}, 8'h01);
    peek(12'h010, d); chk("R1 first pulse frame ignored", d, 8'h00);
    peek(12'h011, d); chk("R1 third pulse frame ignored", d, 8'h00);

    // R2 R7 burst write
    hdr(ID, 1'b0, 16'h0020);
    for (int k = 0; k < 4; k++) tx_buf[3+k] = 8'(8'h11 * k + 3);
    xact(7, 0);
    for (int k = 0; k < 7; k++) if (oe_any[k]) chk("R4 oe during write", 8'h01, 8'h00);
    for (int k = 0; k < 4; k++) begin
      peek(12'(12'h020 + k), d); chk("R7 burst write byte", d, 8'(8'h11 * k + 3));
    end
    // R3 R7 burst read 0x01F..0x024
    hdr(ID, 1'b1, 16'h001F);
    xact(9, 0);
    chk("R3 read 01F", rx_buf[3], 8'h00);
    for (int k = 0; k < 4; k++) chk("R7 burst read byte", rx_buf[4+k], 8'(8'h11 * k + 3));
    chk("R3 read 024", rx_buf[8], 8'h00);
    chk("R4 oe off during header", {5'b0, oe_any[0], oe_any[1], oe_any[2]}, 8'h00);
    chk("R4 oe on from byte 3", {6'b0, oe_any[3], oe_any[8]}, 8'h03);
    chk("R4 oe off after select rise", {7'b0, spi_miso_oe}, 8'h00);

    // R5 wrong chip id
    hdr(7'h39, 1'b0, 16'h0030); tx_buf[3] = 8'h77; xact(4, 0);
    peek(12'h030, d); chk("R5 write with bad id dropped", d, 8'h00);
    hdr(7'h1C, 1'b1, 16'h0020); xact(5, 0);
    chk("R5 read with bad id never drives", {6'b0, oe_any[3], oe_any[4]}, 8'h00);

    // R6 upper subaddress bits ignored
    wr1(16'hF040, 8'hA9);
    peek(12'h040, d); chk("R6 write via padded subaddress", d, 8'hA9);
    hdr(ID, 1'b1, 16'h7040); xact(4, 0);
    chk("R6 read via padded subaddress", rx_buf[3], 8'hA9);

    // R8 partial trailing byte
    hdr(ID, 1'b0, 16'h0050); tx_buf[3] = 8'h6C; tx_buf[4] = 8'hFF; xact(4, 5);
    peek(12'h050, d); chk("R8 full byte kept", d, 8'h6C);
    peek(12'h051, d); chk("R8 partial byte dropped", d, 8'h00);

    // sweep: 32-byte burst write and read
    hdr(ID, 1'b0, 16'h0060);
    for (int k = 0; k < 32; k++) tx_buf[3+k] = 8'((12'h060 + k) * 7 + 1);
    xact(35, 0);
    hdr(ID, 1'b1, 16'h0060); xact(35, 0);
    for (int k = 0; k < 32; k++) begin
      chk("R7 sweep read", rx_buf[3+k], 8'((12'h060 + k) * 7 + 1));
      peek(12'(12'h060 + k), d); chk("R2 sweep stored", d, 8'((12'h060 + k) * 7 + 1));
    end

    // R9 enable combinations
    prev = 8'h00;
    for (int c = 0; c < 8; c++) begin
      wr1(16'h4000, {7'b0, c[2]});
      wr1(16'h4080, {1'b0, c[1], 5'b0, c[0]});
      wr1(16'h00A0, 8'(8'h40 + c));
      if (c == 7) prev = 8'(8'h40 + c);
      peek(12'h0A0, d); chk("R9 guarded write per enable combo", d, prev);
    end
    wr1(16'h00A3, 8'hC7);
    wr1(16'h4000, 8'h00);
    hdr(ID, 1'b1, 16'h00A3); xact(4, 0);
    chk("R9 blocked read returns zero", rx_buf[3], 8'h00);
    peek(12'h0A3, d); chk("R11 host sees guarded byte", d, 8'hC7);
    wr1(16'h4000, 8'h01);
    hdr(ID, 1'b1, 16'h00A3); xact(4, 0);
    chk("R9 open read returns byte", rx_buf[3], 8'hC7);

    // R10 top of file
    hdr(ID, 1'b0, 16'h00BF); tx_buf[3] = 8'h3D; tx_buf[4] = 8'h5E; xact(5, 0);
    peek(12'h0BF, d); chk("R10 last byte written", d, 8'h3D);
    peek(12'h0C0, d); chk("R10 beyond file reads zero", d, 8'h00);
    hdr(ID, 1'b1, 16'h00BF); xact(5, 0);
    chk("R10 read last byte", rx_buf[3], 8'h3D);
    chk("R10 read beyond file", rx_buf[4], 8'h00);
    chk("R1 mode still set", {7'b0, spi_mode}, 8'h01);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule